// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves one 256-byte page of CPU address space into a graphics processor's sprite attribute memory. It watches the CPU bus. When the CPU writes to the trigger address, the block takes the written byte as the page number. It then holds the CPU in a stall and drives the bus itself. For each byte it performs a read from the source page and then a write to a single fixed port address. After the last byte it gives the bus back to the CPU.

The block sits between the CPU core and the memory/peripheral bus. When it is idle the CPU's address, write data and write strobe pass straight through. When it is busy those CPU signals are cut off and the block's own cycles appear on the bus. The memory answers a read in the same cycle the address is presented.

An input that marks the current bus cycle as odd is sampled with the trigger write. If it is set, one dummy alignment cycle comes before the first read.

Top module: `spr_dma_top`

## Requirements
- R1: After reset, `busy` and `cpu_stall` are 0 and the bus outputs mirror the CPU inputs.
- R2: While `busy` is 0, `bus_addr`, `bus_wdata` and `bus_we` equal `cpu_addr`, `cpu_wdata` and `cpu_we` in the same cycle.
- R3: A cycle with `cpu_we`=1 and `cpu_addr`=0x4014 while idle makes `busy` go high at the next clock edge. A write to any other address, or a read of 0x4014, does not start a transfer.
- R4: The read cycles use addresses {P,0x00}, {P,0x01}, … {P,0xFF} in ascending order, where P is the data byte of the trigger write.
- R5: Each read cycle (`bus_we`=0) is followed by one write cycle with `bus_addr`=0x2004 and `bus_wdata` equal to the byte that was on `bus_rdata` during the preceding read.
- R6: Each trigger produces exactly 256 port writes. `busy` stays high for 512 cycles when `cyc_odd`=0 at the trigger, and for 513 cycles when `cyc_odd`=1. The extra cycle comes first and is a non-writing cycle.
- R7: `cpu_stall` equals `busy` in every cycle.
- R8: A trigger write issued while busy is ignored. The page, the write count and the busy length are unchanged, and no CPU signal reaches the bus.
- R9: When the final write completes, `busy` falls, and a new trigger one cycle later is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Address driven by the CPU core |
| cpu_wdata | input | 8 | Write data driven by the CPU core |
| cpu_we | input | 1 | CPU write strobe (1 = write, 0 = read) |
| cyc_odd | input | 1 | High when the current bus cycle is odd; sampled with the trigger |
| bus_rdata | input | 8 | Read data returned by the bus in the same cycle |
| bus_addr | output | 16 | Address on the shared bus |
| bus_wdata | output | 8 | Write data on the shared bus |
| bus_we | output | 1 | Write strobe on the shared bus |
| cpu_stall | output | 1 | Holds the CPU core while the copy runs |
| busy | output | 1 | High while a copy is in progress |

## Verification
A wrong byte index or page register appears within one cycle as a port write that carries data from the wrong source address. The bench compares every write against the arithmetic memory model it provides. A wrong phase bit shows up as two writes in a row or a missing write. A wrong end-of-page condition changes the busy length away from 512 or 513 and the write count away from 256, so it is caught when the transfer ends. A trigger that leaks through during a busy period changes the source page of the remaining writes, and that is seen at the very next write.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dma_state_e;
endpackage

// File: rtl/spr_dma_decode.sv
module spr_dma_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    output logic              trig
);
    always_comb begin
        trig = cpu_we && (cpu_addr == TRIG_ADDR);
    end
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter logic [DATA_W+IDX_W-1:0] PORT_ADDR = 16'h2004
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig,
    input  logic [DATA_W-1:0]       trig_page,
    input  logic                    odd,
    input  logic [DATA_W-1:0]       rdata,
    output logic                    busy,
    output logic [DATA_W+IDX_W-1:0] dma_addr,
    output logic [DATA_W-1:0]       dma_wdata,
    output logic                    dma_we
);
    localparam int ADDR_W = DATA_W + IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        dma_state_e        st;
        logic [DATA_W-1:0] page;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        dma_addr  = {r_q.page, r_q.idx};
        dma_wdata = r_q.data;
        dma_we    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (trig) begin
                    r_d.page = trig_page;
                    r_d.idx  = '0;
                    r_d.st   = odd ? ST_ALIGN : ST_READ;
                end
            end
            ST_ALIGN: begin
                r_d.st = ST_READ;
            end
            ST_READ: begin
                r_d.data = rdata;
                r_d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                dma_addr = PORT_ADDR;
                dma_we   = 1'b1;
                r_d.idx  = r_q.idx + 1'b1;
                r_d.st   = (r_q.idx == LAST_IDX) ? ST_IDLE : ST_READ;
            end
            default: r_d.st = ST_IDLE;
        endcase
        busy = (r_q.st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, page: '0, idx: '0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R3: an idle trigger starts the copy on the next edge
    a_r3_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> busy);

    // R8: a trigger during a copy leaves the page untouched
    a_r8_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> $stable(r_q.page));

    // R6: the last port write ends the copy
    a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_we && r_q.idx == LAST_IDX) |=> !busy);

    // R4: a read of byte k is followed by a read of byte k+1 after the write
    a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_we && r_q.idx != LAST_IDX) |=> (r_q.idx == $past(r_q.idx) + 1'b1));

    logic unused_w;
    assign unused_w = ^ADDR_W;
endmodule

// File: rtl/spr_dma_busmux.sv
module spr_dma_busmux #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              sel_dma,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              dma_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we
);
    always_comb begin
        if (sel_dma) begin
            bus_addr  = dma_addr;
            bus_wdata = dma_wdata;
            bus_we    = dma_we;
        end else begin
            bus_addr  = cpu_addr;
            bus_wdata = cpu_wdata;
            bus_we    = cpu_we;
        end
    end
endmodule

// File: rtl/spr_dma_top.sv
module spr_dma_top #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    parameter logic [DATA_W+IDX_W-1:0] TRIG_ADDR = 16'h4014,
    parameter logic [DATA_W+IDX_W-1:0] PORT_ADDR = 16'h2004
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W+IDX_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    cpu_we,
    input  logic                    cyc_odd,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic [DATA_W+IDX_W-1:0] bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_we,
    output logic                    cpu_stall,
    output logic                    busy
);
    localparam int ADDR_W = DATA_W + IDX_W;

    logic              trig;
    logic              busy_w;
    logic [ADDR_W-1:0] dma_addr;
    logic [DATA_W-1:0] dma_wdata;
    logic              dma_we;

    spr_dma_decode #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .trig     (trig)
    );

    spr_dma_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_ADDR(PORT_ADDR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_page (cpu_wdata),
        .odd       (cyc_odd),
        .rdata     (bus_rdata),
        .busy      (busy_w),
        .dma_addr  (dma_addr),
        .dma_wdata (dma_wdata),
        .dma_we    (dma_we)
    );

    spr_dma_busmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sel_dma   (busy_w),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .dma_addr  (dma_addr),
        .dma_wdata (dma_wdata),
        .dma_we    (dma_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we)
    );

    assign busy      = busy_w;
    assign cpu_stall = busy_w;

    // R5: every write during a copy goes to the sprite port
    a_r5_port_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |-> (bus_addr == PORT_ADDR));

    // R5: copy writes never come back to back
    a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> !(busy && bus_we));

    // R2: idle bus mirrors the CPU
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_addr == cpu_addr && bus_we == cpu_we && bus_wdata == cpu_wdata));
endmodule

// File: tb/sim_spr_dma_top.sv
module sim_spr_dma_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        cyc_odd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic        cpu_stall;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign bus_rdata = memf(bus_addr);

    spr_dma_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cyc_odd(cyc_odd), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .cpu_stall(cpu_stall), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    logic [7:0]  mon_page = '0;
    int          busy_cyc = 0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [15:0] last_rd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cpu_stall == busy, "R7 stall", int'(cpu_stall), int'(busy));
            if (busy) begin
                busy_cyc++;
                if (bus_we) begin
                    chk(bus_addr == 16'h2004, "R5 port addr", int'(bus_addr), 'h2004);
                    chk(last_rd == {mon_page, wr_cnt[7:0]}, "R4 read addr",
                        int'(last_rd), int'({mon_page, wr_cnt[7:0]}));
                    chk(bus_wdata == memf({mon_page, wr_cnt[7:0]}), "R5 data",
                        int'(bus_wdata), int'(memf({mon_page, wr_cnt[7:0]})));
                    wr_cnt++;
                end else begin
                    rd_cnt++;
                    last_rd = bus_addr;
                end
            end
        end
    end

    task automatic run_dma(input logic [7:0] page, input bit odd, input bit dup);
        @(negedge clk);
        busy_cyc = 0; wr_cnt = 0; rd_cnt = 0; mon_page = page;
        cpu_addr = 16'h4014; cpu_wdata = page; cpu_we = 1'b1; cyc_odd = odd;
        @(negedge clk);
        cpu_we = 1'b0; cyc_odd = 1'b0;
        chk(busy == 1'b1, "R3 start", int'(busy), 1);
        if (dup) begin
            repeat (40) @(negedge clk);
            // R8: repeated trigger with another page while busy
            cpu_addr = 16'h4014; cpu_wdata = ~page; cpu_we = 1'b1;
            repeat (4) @(negedge clk);
            cpu_addr = 16'h0300; cpu_wdata = 8'hEE;
            repeat (3) @(negedge clk);
            cpu_we = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(busy_cyc == 512 + int'(odd), "R6 busy length", busy_cyc, 512 + int'(odd));
        chk(wr_cnt == 256, "R6 write count", wr_cnt, 256);
        chk(rd_cnt == 256 + int'(odd), "R6 read count", rd_cnt, 256 + int'(odd));
        chk(cpu_stall == 1'b0, "R9 stall released", int'(cpu_stall), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(cpu_stall == 1'b0, "R1 stall", int'(cpu_stall), 0);
        chk(bus_addr == cpu_addr, "R1 bus addr", int'(bus_addr), int'(cpu_addr));
        rst_n = 1'b1;
        @(negedge clk);
        // R2 pass-through
        cpu_addr = 16'h1234; cpu_wdata = 8'hA5; cpu_we = 1'b1;
        #1;
        chk(bus_addr == 16'h1234, "R2 addr", int'(bus_addr), 'h1234);
        chk(bus_wdata == 8'hA5, "R2 wdata", int'(bus_wdata), 'hA5);
        chk(bus_we == 1'b1, "R2 we", int'(bus_we), 1);
        // R3 non-trigger write and trigger-address read
        @(negedge clk);
        cpu_addr = 16'h4015; cpu_wdata = 8'h02;
        @(negedge clk);
        chk(busy == 1'b0, "R3 other addr", int'(busy), 0);
        cpu_addr = 16'h4014; cpu_we = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R3 read no start", int'(busy), 0);
        // R4 R5 R6 copies over several pages
        run_dma(8'h00, 1'b0, 1'b0);
        run_dma(8'h5A, 1'b1, 1'b0);
        run_dma(8'hFF, 1'b0, 1'b0);
        // R8 ignored re-trigger, R9 back to back
        run_dma(8'h3C, 1'b0, 1'b1);
        run_dma(8'h81, 1'b1, 1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule